// File: doc/BRIEF.md
# UART Transmit/Receive Byte Queue Controller

This block holds the transmit and receive byte queues of a 16550-style serial port together with the write-only control register that governs them. A single control write switches both queues between queued operation (sixteen bytes each) and single-byte holding operation. The same write can also flush either queue on its own, or both together. The serial shift registers lie outside the block, so no flush ever reaches a byte that is already being shifted.

Each queue has a push side (the host for transmit, the receive shifter for receive) and a pop side. Each reports its occupancy and its empty and full flags. The pop data is shown ahead: the oldest byte is visible on the data output whenever the queue is not empty. A 2-bit trigger-level field is kept for the interrupt logic outside the block. There is no DMA mode.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset, queued mode is off, the trigger level is 0, both counts are 0, both empty flags are 1 and both full flags are 0.
- R2: A control write with bit 0 = 1 turns queued mode on (`fifo_mode` = 1) and stores bits 7:6 as the trigger level. In queued mode each queue holds up to 16 bytes.
- R3: A control write with bit 0 = 0 turns queued mode off and empties both queues, whatever bits 1 and 2 hold.
- R4: A control write with bits 0 and 1 both set empties the receive queue and leaves the transmit queue untouched. The flush acts only in the cycle of the write, so pushes in later cycles are accepted.
- R5: A control write with bits 0 and 2 both set empties the transmit queue and leaves the receive queue untouched. The flush acts only in the cycle of the write.
- R6: A control write with bit 0 = 0 leaves the trigger level unchanged.
- R7: Bytes leave each queue in the order they were pushed. The pop data shows the oldest byte, and each count equals the number of bytes held.
- R8: A push to a full queue and a pop from an empty queue are ignored.
- R9: When a flush of a queue and a push or pop on that queue fall in the same cycle, the flush wins and the queue ends empty.
- R10: With queued mode off, each queue holds at most one byte, and full is set when one byte is held.
- R11: A push and a pop in the same cycle on a queue that is neither empty nor full leave its count unchanged and advance its contents by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_data | input | 8 | Control write data: bit 0 enable, bit 1 receive flush, bit 2 transmit flush, bits 7:6 trigger level |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_push_data | input | 8 | Byte to push into the transmit queue |
| tx_pop | input | 1 | Remove the oldest transmit byte |
| tx_pop_data | output | 8 | Oldest transmit byte |
| tx_count | output | 5 | Transmit occupancy |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_push | input | 1 | Push a byte into the receive queue |
| rx_push_data | input | 8 | Byte to push into the receive queue |
| rx_pop | input | 1 | Remove the oldest receive byte |
| rx_pop_data | output | 8 | Oldest receive byte |
| rx_count | output | 5 | Receive occupancy |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| fifo_mode | output | 1 | Queued mode active |
| trig_level | output | 2 | Stored receive trigger-level field |

## Verification
A control write that flushes a queue can land in the same cycle as a push or a pop on that queue. The bench provokes this with directed cycles that assert a flush write together with push and pop on both sides, and with a random phase that mixes control writes into dense traffic. A behavioural queue model applies the flush before any push or pop. Every clock it is compared against the counts, the flags, the mode, the trigger level and the shown-ahead byte, so a design that lets a byte slip past the flush shows up as a count mismatch.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int CTL_EN_BIT    = 0;
  localparam int CTL_RXFL_BIT  = 1;
  localparam int CTL_TXFL_BIT  = 2;
  localparam int CTL_TRIG_LSB  = 6;
  localparam int TRIG_W        = 2;

  typedef struct packed {
    logic              en;
    logic              rx_flush;
    logic              tx_flush;
    logic [TRIG_W-1:0] trig;
  } ctl_cmd_t;

  function automatic ctl_cmd_t decode_ctl(input logic [7:0] d);
    ctl_cmd_t c;
    c.en       = d[CTL_EN_BIT];
    c.rx_flush = d[CTL_RXFL_BIT];
    c.tx_flush = d[CTL_TXFL_BIT];
    c.trig     = d[CTL_TRIG_LSB +: TRIG_W];
    return c;
  endfunction
endpackage

// File: rtl/uart_fcr_decode.sv
module uart_fcr_decode
  import uart_fifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic              mode_q,
  output logic [TRIG_W-1:0] trig_q,
  output logic              rx_flush,
  output logic              tx_flush
);
  ctl_cmd_t          cmd;
  logic              mode_d;
  logic [TRIG_W-1:0] trig_d;

  always_comb begin
    cmd      = decode_ctl(wr_data);
    mode_d   = mode_q;
    trig_d   = trig_q;
    rx_flush = 1'b0;
    tx_flush = 1'b0;
    if (wr_en) begin
      mode_d = cmd.en;
      if (cmd.en) begin
        trig_d   = cmd.trig;
        rx_flush = cmd.rx_flush;
        tx_flush = cmd.tx_flush;
      end else begin
        rx_flush = 1'b1;
        tx_flush = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      trig_q <= '0;
    end else if (wr_en) begin
      mode_q <= mode_d;
      trig_q <= trig_d;
    end
  end
endmodule

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          single,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, wr_ptr_d, rd_ptr, rd_ptr_d;
  logic [CW-1:0] count_d, limit;
  logic          push_ok, pop_ok, ptr_en;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + AW'(1);
  endfunction

  assign limit    = single ? CW'(1) : CW'(DEPTH);
  assign empty    = (count == '0);
  assign full     = (count == limit);
  assign pop_data = mem[rd_ptr];

  always_comb begin
    push_ok  = push && !full && !flush;
    pop_ok   = pop && !empty && !flush;
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    count_d  = count;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (push_ok) wr_ptr_d = ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr_d = ptr_inc(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count_d = count + CW'(1);
        2'b01:   count_d = count - CW'(1);
        default: count_d = count;
      endcase
    end
    ptr_en = flush || push_ok || pop_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (ptr_en) begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_data,
  input  logic          tx_push,
  input  logic [W-1:0]  tx_push_data,
  input  logic          tx_pop,
  output logic [W-1:0]  tx_pop_data,
  output logic [CW-1:0] tx_count,
  output logic          tx_empty,
  output logic          tx_full,
  input  logic          rx_push,
  input  logic [W-1:0]  rx_push_data,
  input  logic          rx_pop,
  output logic [W-1:0]  rx_pop_data,
  output logic [CW-1:0] rx_count,
  output logic          rx_empty,
  output logic          rx_full,
  output logic          fifo_mode,
  output logic [1:0]    trig_level
);
  logic rx_flush, tx_flush;

  uart_fcr_decode i_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctl_wr),
    .wr_data  (ctl_data),
    .mode_q   (fifo_mode),
    .trig_q   (trig_level),
    .rx_flush (rx_flush),
    .tx_flush (tx_flush)
  );

  uart_byte_fifo #(.DEPTH(DEPTH), .W(W)) i_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (tx_flush),
    .single    (!fifo_mode),
    .push      (tx_push),
    .push_data (tx_push_data),
    .pop       (tx_pop),
    .pop_data  (tx_pop_data),
    .count     (tx_count),
    .empty     (tx_empty),
    .full      (tx_full)
  );

  uart_byte_fifo #(.DEPTH(DEPTH), .W(W)) i_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (rx_flush),
    .single    (!fifo_mode),
    .push      (rx_push),
    .push_data (rx_push_data),
    .pop       (rx_pop),
    .pop_data  (rx_pop_data),
    .count     (rx_count),
    .empty     (rx_empty),
    .full      (rx_full)
  );
endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_wr,
  input logic [7:0]    ctl_data,
  input logic          tx_push,
  input logic          tx_pop,
  input logic          rx_push,
  input logic          rx_pop,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic          tx_full,
  input logic          tx_empty,
  input logic          fifo_mode,
  input logic [1:0]    trig_level
);
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !ctl_data[0] |=> !fifo_mode && tx_count == '0 && rx_count == '0); // R3
  AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_data[0] && ctl_data[1] |=> rx_count == '0); // R4
  AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_data[0] && ctl_data[2] |=> tx_count == '0); // R5
  AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !ctl_data[0] |=> $stable(trig_level)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CW'(DEPTH) && rx_count <= CW'(DEPTH)); // R8
  AST_FULL_PUSH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full && tx_push && !tx_pop && !ctl_wr |=> $stable(tx_count)); // R8
  AST_SINGLE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |-> tx_count <= CW'(1) && rx_count <= CW'(1)); // R10
  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_full && !tx_empty && tx_push && tx_pop && !ctl_wr |=> $stable(tx_count)); // R11
endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DEPTH(DEPTH)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_wr     (ctl_wr),
  .ctl_data   (ctl_data),
  .tx_push    (tx_push),
  .tx_pop     (tx_pop),
  .rx_push    (rx_push),
  .rx_pop     (rx_pop),
  .tx_count   (tx_count),
  .rx_count   (rx_count),
  .tx_full    (tx_full),
  .tx_empty   (tx_empty),
  .fifo_mode  (fifo_mode),
  .trig_level (trig_level)
);

// File: tb/test_uart_fifo_ctl.sv
`timescale 1ns/1ps
module test_uart_fifo_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_data = '0;
  logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_push_data = '0, rx_push_data = '0;
  logic [7:0] tx_pop_data, rx_pop_data;
  logic [4:0] tx_count, rx_count;
  logic       tx_empty, tx_full, rx_empty, rx_full, fifo_mode;
  logic [1:0] trig_level;

  always #5 clk = ~clk;

  uart_fifo_ctl i_uart_fifo_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop),
    .tx_pop_data(tx_pop_data), .tx_count(tx_count), .tx_empty(tx_empty), .tx_full(tx_full),
    .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop),
    .rx_pop_data(rx_pop_data), .rx_count(rx_count), .rx_empty(rx_empty), .rx_full(rx_full),
    .fifo_mode(fifo_mode), .trig_level(trig_level)
  );

  int checks = 0;
  int fails  = 0;
  logic [7:0] mq_tx[$];
  logic [7:0] mq_rx[$];
  logic       m_mode = 1'b0;
  logic [1:0] m_trig = 2'b00;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string req);
    int cap;
    cap = m_mode ? 16 : 1;
    chk(req, "fifo_mode", fifo_mode, m_mode);
    chk(req, "trig_level", trig_level, m_trig);
    chk(req, "tx_count", tx_count, mq_tx.size());
    chk(req, "rx_count", rx_count, mq_rx.size());
    chk(req, "tx_empty", tx_empty, mq_tx.size() == 0);
    chk(req, "rx_empty", rx_empty, mq_rx.size() == 0);
    chk(req, "tx_full", tx_full, mq_tx.size() == cap);
    chk(req, "rx_full", rx_full, mq_rx.size() == cap);
    if (mq_tx.size() > 0) chk(req, "tx_pop_data", tx_pop_data, mq_tx[0]);
    if (mq_rx.size() > 0) chk(req, "rx_pop_data", rx_pop_data, mq_rx[0]);
  endtask

  task automatic model_q(ref logic [7:0] q[$], input bit fl, input bit ps,
                         input logic [7:0] pd, input bit pp, input int cap);
    bit pop_ok, push_ok;
    if (fl) begin
      q.delete();
      return;
    end
    pop_ok  = pp && q.size() > 0;
    push_ok = ps && q.size() < cap;
    if (pop_ok)  void'(q.pop_front());
    if (push_ok) q.push_back(pd);
  endtask

  // one clock: drive at the falling edge, update model at the rising edge, compare at the next falling edge
  task automatic step(input string req, input bit wr, input logic [7:0] d,
                      input bit tps, input logic [7:0] td, input bit tpp,
                      input bit rps, input logic [7:0] rd, input bit rpp);
    int  cap;
    bit  fl_tx, fl_rx;
    ctl_wr = wr; ctl_data = d;
    tx_push = tps; tx_push_data = td; tx_pop = tpp;
    rx_push = rps; rx_push_data = rd; rx_pop = rpp;
    cap   = m_mode ? 16 : 1;
    fl_rx = wr && (!d[0] || d[1]);
    fl_tx = wr && (!d[0] || d[2]);
    @(posedge clk);
    model_q(mq_tx, fl_tx, tps, td, tpp, cap);
    model_q(mq_rx, fl_rx, rps, rd, rpp, cap);
    if (wr) begin
      m_mode = d[0];
      if (d[0]) m_trig = d[7:6];
    end
    @(negedge clk);
    ctl_wr = 1'b0; tx_push = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
    compare_all(req);
  endtask

  task automatic idle(input string req);
    step(req, 0, 8'h00, 0, 8'h00, 0, 0, 8'h00, 0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");

    // R10: holding mode takes one byte only; R8: pop from empty ignored
    step("R10", 0, 8'h00, 1, 8'hA1, 0, 1, 8'hB1, 0);
    step("R10", 0, 8'h00, 1, 8'hA2, 0, 1, 8'hB2, 0);
    step("R7",  0, 8'h00, 0, 8'h00, 1, 0, 8'h00, 1);
    step("R8",  0, 8'h00, 0, 8'h00, 1, 0, 8'h00, 1);

    // R2: enter queued mode with trigger level 2
    step("R2", 1, 8'h81, 0, 8'h00, 0, 0, 8'h00, 0);
    for (int i = 0; i < 18; i++)
      step("R8", 0, 8'h00, 1, 8'(8'h10 + i), 0, 1, 8'(8'h40 + i), 0);
    step("R8", 0, 8'h00, 1, 8'hEE, 0, 1, 8'hEE, 0);
    for (int i = 0; i < 3; i++) step("R7", 0, 8'h00, 0, 8'h00, 1, 0, 8'h00, 1);
    for (int i = 0; i < 4; i++)
      step("R11", 0, 8'h00, 1, 8'(8'h70 + i), 1, 1, 8'(8'h90 + i), 1);

    // R4 and R5: single-queue flushes, then pushes accepted again
    step("R4", 1, 8'h43, 0, 8'h00, 0, 0, 8'h00, 0);
    step("R4", 0, 8'h00, 0, 8'h00, 0, 1, 8'h5A, 0);
    step("R5", 1, 8'h05, 0, 8'h00, 0, 0, 8'h00, 0);
    step("R5", 0, 8'h00, 1, 8'hC3, 0, 0, 8'h00, 0);
    step("R5", 0, 8'h00, 1, 8'hC4, 0, 1, 8'h5B, 0);

    // R9: flush of both with push and pop in the same cycle
    step("R9", 1, 8'h07, 1, 8'h11, 1, 1, 8'h22, 1);
    step("R9", 0, 8'h00, 1, 8'h33, 0, 1, 8'h44, 0);
    step("R9", 1, 8'h03, 1, 8'h55, 0, 1, 8'h66, 0);

    // R3 and R6: disable with other bits set
    step("R3", 0, 8'h00, 1, 8'h77, 0, 1, 8'h88, 0);
    step("R6", 1, 8'hC6, 0, 8'h00, 0, 0, 8'h00, 0);
    step("R10", 0, 8'h00, 1, 8'h99, 0, 1, 8'hAA, 0);
    step("R10", 0, 8'h00, 1, 8'h9A, 0, 1, 8'hAB, 0);
    step("R3", 1, 8'h00, 0, 8'h00, 0, 0, 8'h00, 0);
    idle("R1");

    // mixed traffic with occasional control writes
    step("R2", 1, 8'h41, 0, 8'h00, 0, 0, 8'h00, 0);
    for (int i = 0; i < 600; i++) begin
      bit wr;
      logic [7:0] d;
      wr = ($urandom_range(0, 19) == 0);
      d  = 8'($urandom());
      if ($urandom_range(0, 3) != 0) d[0] = 1'b1;
      step("R9", wr, d,
           $urandom_range(0, 2) != 0, 8'($urandom()), $urandom_range(0, 2) == 0,
           $urandom_range(0, 2) == 0, 8'($urandom()), $urandom_range(0, 2) != 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule